// File: doc/BRIEF.md
# Banked Internal Data Memory with Special-Register Window

This block is the on-chip data address space of an 8-bit controller core. It holds a RAM of 128 or 256 bytes (chosen by `RAM_BYTES`), a separate 128-byte file of special-function registers, and a stack pointer. The core reaches the space through several access paths that act on one shared storage. Byte access can be direct or indirect. Working registers are reached by number within a selected bank. Single bits can be read, set or cleared. Push and pop use the stack pointer.

The byte range 0x80–0xFF is overloaded. A direct access there reaches the special-function register file, and a write there is also announced on a hook so that a peripheral can follow it. An indirect access there reaches the upper half of RAM. The eight working registers are a sliding view into the bottom 32 bytes of RAM, moved by the bank select. The 16 bytes from 0x20 also answer to 128 bit addresses. All reads are combinational from the current inputs, and all writes take effect at the rising clock edge.

Top module: `idata_space`

## Requirements
- R1: Reset (`rst_n` low) sets the stack pointer to 0x07 and the bank to 0. RAM contents are not changed by reset.
- R2: `bank_load` loads `bank_in` into the bank register at the next edge. Register number n (0–7) reads and writes RAM byte bank*8+n.
- R3: A direct or indirect byte access to 0x00–0x7F reads and writes RAM at that address.
- R4: A direct byte access to 0x80–0xFF reaches the special-function file at offset addr-0x80, which is separate from upper RAM. A direct write there drives `sfr_we_o` high, with `sfr_addr_o` set to the offset and `sfr_wdata_o` set to the data, in the same cycle.
- R5: An indirect byte access to 0x80–0xFF reaches upper RAM when `RAM_BYTES` is 256. When `RAM_BYTES` is 128, such a read returns 0x00 and such a write is dropped.
- R6: Bit address b (0–127) reads bit b mod 8 of RAM byte 0x20 + b/8 on `bt_rdata`.
- R7: With `bt_en` high, `bt_op` 2'b01 sets the addressed bit and 2'b10 clears it, leaving the other seven bits of that byte unchanged. The codes 2'b00 and 2'b11 only read.
- R8: A push adds 1 to the stack pointer and writes `st_wdata` at the new pointer value.
- R9: `st_rdata` shows RAM at the stack pointer. A pop subtracts 1 from the pointer at the edge. The pointer wraps modulo 256 in both directions.
- R10: At most one storage write happens per edge, with priority push, then byte write, then register write, then bit set/clear. When push and pop arrive together, only the push acts.
- R11: With `RAM_BYTES` of 128, a push to a pointer value of 0x80 or above still moves the pointer but writes nothing. Reads at such a pointer return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_load | input | 1 | Load the bank select |
| bank_in | input | 2 | New bank number |
| by_en | input | 1 | Byte access enable |
| by_we | input | 1 | Byte write when high, read otherwise |
| by_indirect | input | 1 | Indirect mode when high, direct mode otherwise |
| by_addr | input | 8 | Byte address |
| by_wdata | input | 8 | Byte write data |
| by_rdata | output | 8 | Byte read data |
| rg_en | input | 1 | Working register access enable |
| rg_we | input | 1 | Working register write |
| rg_num | input | 3 | Register number in the current bank |
| rg_wdata | input | 8 | Register write data |
| rg_rdata | output | 8 | Register read data |
| bt_en | input | 1 | Bit access enable |
| bt_op | input | 2 | 01 set, 10 clear, other codes read only |
| bt_addr | input | 7 | Bit address |
| bt_rdata | output | 1 | Current value of the addressed bit |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| st_wdata | input | 8 | Data to push |
| st_rdata | output | 8 | Byte at the stack pointer |
| sp_o | output | 8 | Stack pointer |
| sfr_we_o | output | 1 | Peripheral hook: special register written |
| sfr_addr_o | output | 7 | Peripheral hook: register offset |
| sfr_wdata_o | output | 8 | Peripheral hook: written data |

## Verification
The hardest states to reach are those where the stack pointer sits at a range boundary. These are the wrap from 0xFF to 0x00 in the large variant and the crossing of 0x7F in the small one, and getting there takes hundreds of pushes. Directed loops drive the pointer to each boundary, while a reference model of the whole RAM and register file follows every write. Because the model is also exact during randomised mixed traffic, every read across bank changes, bit updates and overlapping address windows is compared against a known value. A second instance with 128 bytes covers the dropped indirect and stack accesses.

// File: rtl/idata_space.sv
module idata_space #(
  parameter int RAM_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_load,
  input  logic [1:0] bank_in,
  input  logic       by_en,
  input  logic       by_we,
  input  logic       by_indirect,
  input  logic [7:0] by_addr,
  input  logic [7:0] by_wdata,
  output logic [7:0] by_rdata,
  input  logic       rg_en,
  input  logic       rg_we,
  input  logic [2:0] rg_num,
  input  logic [7:0] rg_wdata,
  output logic [7:0] rg_rdata,
  input  logic       bt_en,
  input  logic [1:0] bt_op,
  input  logic [6:0] bt_addr,
  output logic       bt_rdata,
  input  logic       push,
  input  logic       pop,
  input  logic [7:0] st_wdata,
  output logic [7:0] st_rdata,
  output logic [7:0] sp_o,
  output logic       sfr_we_o,
  output logic [6:0] sfr_addr_o,
  output logic [7:0] sfr_wdata_o
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [8:0] LIMIT = 9'(RAM_BYTES);

  logic [7:0] ram [RAM_BYTES];
  logic [7:0] sfr [128];
  logic [7:0] sp_q;
  logic [1:0] bank_q;

  logic       by_sfr, by_ram, push_ok, st_ok, bt_wr;
  logic [7:0] sp_inc, rg_addr, bt_byte;

  assign by_sfr  = ~by_indirect & by_addr[7];
  assign by_ram  = by_indirect ? ({1'b0, by_addr} < LIMIT) : ~by_addr[7];
  assign sp_inc  = sp_q + 8'd1;
  assign push_ok = {1'b0, sp_inc} < LIMIT;
  assign st_ok   = {1'b0, sp_q} < LIMIT;
  assign rg_addr = {3'b000, bank_q, rg_num};
  assign bt_byte = {4'b0010, bt_addr[6:3]};
  assign bt_wr   = bt_en & (bt_op == 2'b01 || bt_op == 2'b10);

  assign by_rdata = by_sfr ? sfr[by_addr[6:0]] :
                    by_ram ? ram[by_addr[AW-1:0]] : 8'h00;
  assign rg_rdata = ram[rg_addr[AW-1:0]];
  assign bt_rdata = ram[bt_byte[AW-1:0]][bt_addr[2:0]];
  assign st_rdata = st_ok ? ram[sp_q[AW-1:0]] : 8'h00;
  assign sp_o     = sp_q;

  assign sfr_we_o    = by_en & by_we & by_sfr & ~push;
  assign sfr_addr_o  = by_addr[6:0];
  assign sfr_wdata_o = by_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q   <= 8'h07;
      bank_q <= 2'd0;
    end else begin
      if (bank_load) bank_q <= bank_in;
      if (push)      sp_q <= sp_inc;
      else if (pop)  sp_q <= sp_q - 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      if (push_ok) ram[sp_inc[AW-1:0]] <= st_wdata;
    end else if (by_en && by_we) begin
      if (by_sfr)      sfr[by_addr[6:0]] <= by_wdata;
      else if (by_ram) ram[by_addr[AW-1:0]] <= by_wdata;
    end else if (rg_en && rg_we) begin
      ram[rg_addr[AW-1:0]] <= rg_wdata;
    end else if (bt_wr) begin
      ram[bt_byte[AW-1:0]][bt_addr[2:0]] <= bt_op[0];
    end
  end
endmodule

// File: rtl/idata_space_chk.sv
module idata_space_chk #(
  parameter int RAM_BYTES = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_load,
  input logic [1:0] bank_in,
  input logic [1:0] bank_q,
  input logic       by_en,
  input logic       by_indirect,
  input logic [7:0] by_addr,
  input logic [7:0] by_rdata,
  input logic       push,
  input logic       pop,
  input logic [7:0] st_wdata,
  input logic [7:0] st_rdata,
  input logic [7:0] sp_o,
  input logic       sfr_we_o
);
  p_sp_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_o == $past(sp_o) + 8'd1);

  p_sp_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_o == $past(sp_o) - 8'd1);

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(sp_o));

  p_push_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ((9'(sp_o) + 9'd1) < 9'(RAM_BYTES))) |=> st_rdata == $past(st_wdata));

  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> bank_q == $past(bank_in));

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_q));

  p_push_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !sfr_we_o);

  always_comb begin
    if (rst_n && RAM_BYTES == 128 && by_en && by_indirect && by_addr[7])
      p_small_upper_r5: assert (by_rdata == 8'h00);
  end
endmodule

bind idata_space idata_space_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_in(bank_in),
  .bank_q(bank_q), .by_en(by_en), .by_indirect(by_indirect),
  .by_addr(by_addr), .by_rdata(by_rdata), .push(push), .pop(pop),
  .st_wdata(st_wdata), .st_rdata(st_rdata), .sp_o(sp_o), .sfr_we_o(sfr_we_o)
);

// File: tb/idata_space_test.sv
module idata_space_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic bank_load = 0; logic [1:0] bank_in = 0;
  logic by_en = 0, by_we = 0, by_indirect = 0;
  logic [7:0] by_addr = 0, by_wdata = 0, by_rdata;
  logic rg_en = 0, rg_we = 0; logic [2:0] rg_num = 0;
  logic [7:0] rg_wdata = 0, rg_rdata;
  logic bt_en = 0; logic [1:0] bt_op = 0; logic [6:0] bt_addr = 0; logic bt_rdata;
  logic push = 0, pop = 0; logic [7:0] st_wdata = 0, st_rdata, sp_o;
  logic sfr_we_o; logic [6:0] sfr_addr_o; logic [7:0] sfr_wdata_o;

  idata_space #(.RAM_BYTES(256)) uut (.*);

  logic s_by_en = 0, s_by_we = 0, s_by_ind = 0, s_push = 0;
  logic [7:0] s_addr = 0, s_wdata = 0, s_st_wdata = 0;
  logic [7:0] s_rdata, s_rg_rdata, s_st_rdata, s_sp, s_sfr_wdata;
  logic s_bt_rdata, s_sfr_we; logic [6:0] s_sfr_addr;

  idata_space #(.RAM_BYTES(128)) uut_small (
    .clk(clk), .rst_n(rst_n), .bank_load(1'b0), .bank_in(2'd0),
    .by_en(s_by_en), .by_we(s_by_we), .by_indirect(s_by_ind),
    .by_addr(s_addr), .by_wdata(s_wdata), .by_rdata(s_rdata),
    .rg_en(1'b0), .rg_we(1'b0), .rg_num(3'd0), .rg_wdata(8'd0), .rg_rdata(s_rg_rdata),
    .bt_en(1'b0), .bt_op(2'd0), .bt_addr(7'd0), .bt_rdata(s_bt_rdata),
    .push(s_push), .pop(1'b0), .st_wdata(s_st_wdata), .st_rdata(s_st_rdata),
    .sp_o(s_sp), .sfr_we_o(s_sfr_we), .sfr_addr_o(s_sfr_addr), .sfr_wdata_o(s_sfr_wdata));

  logic [7:0] mram [256];
  logic [7:0] msfr [128];
  logic [7:0] msp;
  logic [1:0] mbank;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic ind, logic [7:0] a);
    return (!ind && a[7]) ? msfr[a[6:0]] : mram[a];
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic idle();
    bank_load = 0; by_en = 0; by_we = 0; rg_en = 0; rg_we = 0;
    bt_en = 0; bt_op = 0; push = 0; pop = 0;
  endtask

  task automatic byte_wr(logic ind, logic [7:0] a, logic [7:0] d);
    by_en = 1; by_we = 1; by_indirect = ind; by_addr = a; by_wdata = d; tick(); idle();
    if (!ind && a[7]) msfr[a[6:0]] = d; else mram[a] = d;
  endtask

  task automatic byte_rd(logic ind, logic [7:0] a, string req);
    by_en = 1; by_we = 0; by_indirect = ind; by_addr = a; #1;
    chk(req, by_rdata, exp_byte(ind, a)); idle();
  endtask

  task automatic reg_wr(logic [2:0] n, logic [7:0] d);
    rg_en = 1; rg_we = 1; rg_num = n; rg_wdata = d; tick(); idle();
    mram[{3'b0, mbank, n}] = d;
  endtask

  task automatic reg_rd(logic [2:0] n);
    rg_en = 1; rg_num = n; #1; chk("R2 reg read", rg_rdata, mram[{3'b0, mbank, n}]); idle();
  endtask

  task automatic set_bank(logic [1:0] b);
    bank_load = 1; bank_in = b; tick(); idle(); mbank = b;
  endtask

  task automatic bit_op(logic [1:0] op, logic [6:0] b);
    logic [7:0] ba;
    ba = 8'h20 + {4'b0, b[6:3]};
    bt_en = 1; bt_op = op; bt_addr = b; #1;
    chk("R6 bit read", bt_rdata, mram[ba][b[2:0]]);
    tick(); idle();
    if (op == 2'b01) mram[ba][b[2:0]] = 1'b1;
    else if (op == 2'b10) mram[ba][b[2:0]] = 1'b0;
  endtask

  task automatic do_push(logic [7:0] d);
    push = 1; st_wdata = d; tick(); idle();
    msp = msp + 8'd1; mram[msp] = d;
  endtask

  task automatic do_pop();
    #1; chk("R9 pop data", st_rdata, mram[msp]);
    pop = 1; tick(); idle(); msp = msp - 8'd1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24680));
    idle();
    repeat (3) tick();
    rst_n = 1; tick();
    msp = 8'h07; mbank = 0;
    chk("R1 reset sp", sp_o, 8'h07);
    chk("R1 reset sp small", s_sp, 8'h07);

    for (int a = 0; a < 256; a++) byte_wr(1'b1, 8'(a), 8'(a * 37 + 11));
    for (int a = 128; a < 256; a++) byte_wr(1'b0, 8'(a), 8'(a * 91 + 5));

    reg_wr(3'd3, 8'hC3);
    byte_rd(1'b0, 8'h03, "R1 bank 0 after reset");
    mram[8'h40] = 8'h77; byte_wr(1'b0, 8'h40, 8'h77);
    rst_n = 0; tick(); rst_n = 1; tick(); msp = 8'h07; mbank = 0;
    byte_rd(1'b0, 8'h40, "R1 ram kept over reset");

    set_bank(2'd2); reg_wr(3'd5, 8'hA5);
    byte_rd(1'b0, 8'h15, "R2 bank2 R5 at 0x15");
    set_bank(2'd3); reg_rd(3'd7);

    byte_wr(1'b0, 8'h55, 8'h3C); byte_rd(1'b1, 8'h55, "R3 direct low");
    byte_wr(1'b1, 8'h9A, 8'h11); byte_wr(1'b0, 8'h9A, 8'h22);
    byte_rd(1'b1, 8'h9A, "R5 indirect upper ram");
    byte_rd(1'b0, 8'h9A, "R4 direct sfr separate");

    by_en = 1; by_we = 1; by_indirect = 0; by_addr = 8'hC4; by_wdata = 8'h6E; #1;
    chk("R4 hook we", sfr_we_o, 1'b1);
    chk("R4 hook addr", sfr_addr_o, 7'h44);
    chk("R4 hook data", sfr_wdata_o, 8'h6E);
    tick(); idle(); msfr[7'h44] = 8'h6E;

    byte_wr(1'b0, 8'h2A, 8'b1010_0101);
    bit_op(2'b01, 7'h51); byte_rd(1'b0, 8'h2A, "R7 set one bit");
    bit_op(2'b10, 7'h57); byte_rd(1'b0, 8'h2A, "R7 clear one bit");
    bit_op(2'b11, 7'h50); byte_rd(1'b0, 8'h2A, "R7 code 11 read only");

    set_bank(2'd0);
    by_en = 1; by_we = 1; by_indirect = 1; by_addr = 8'h60; by_wdata = 8'hB1;
    rg_en = 1; rg_we = 1; rg_num = 3'd1; rg_wdata = 8'hB2; tick(); idle();
    mram[8'h60] = 8'hB1;
    byte_rd(1'b1, 8'h60, "R10 byte write wins");
    byte_rd(1'b0, 8'h01, "R10 register write dropped");
    push = 1; pop = 1; st_wdata = 8'h4D; tick(); idle();
    msp = msp + 8'd1; mram[msp] = 8'h4D;
    chk("R10 push over pop sp", sp_o, msp);
    do_push(8'h81); chk("R8 push sp", sp_o, msp);
    do_pop(); do_pop(); chk("R9 sp after pops", sp_o, msp);

    for (int i = 0; i < 400; i++) begin
      automatic int k = $urandom % 9;
      automatic logic [7:0] a = 8'($urandom);
      automatic logic [7:0] d = 8'($urandom);
      automatic logic ind = 1'($urandom);
      case (k)
        0: byte_wr(ind, a, d);
        1: byte_rd(ind, a, "R3 random byte");
        2: reg_wr(a[2:0], d);
        3: reg_rd(a[2:0]);
        4: bit_op(d[1:0], a[6:0]);
        5: do_push(d);
        6: do_pop();
        7: set_bank(d[1:0]);
        default: begin #1; chk("R9 sp track", sp_o, msp); end
      endcase
    end

    while (msp != 8'hFF) do_push(8'($urandom));
    do_push(8'hE7);
    chk("R9 wrap up sp", sp_o, 8'h00);
    byte_rd(1'b0, 8'h00, "R9 wrap write at 0");
    do_pop(); chk("R9 wrap down sp", sp_o, 8'hFF);

    s_by_en = 1; s_by_we = 1; s_by_ind = 1; s_addr = 8'h90; s_wdata = 8'h5A; tick();
    s_by_we = 0; #1; chk("R5 small indirect upper reads 0", s_rdata, 8'h00);
    s_by_we = 1; s_by_ind = 0; s_wdata = 8'h3B; tick();
    s_by_we = 0; #1; chk("R4 small direct sfr", s_rdata, 8'h3B);
    s_by_we = 1; s_by_ind = 1; s_addr = 8'h10; s_wdata = 8'hC8; tick();
    s_by_we = 0; #1; chk("R3 small indirect low", s_rdata, 8'hC8);
    s_by_en = 0;
    for (int i = 0; i < 120; i++) begin s_push = 1; s_st_wdata = 8'(i + 1); tick(); end
    s_push = 0; #1;
    chk("R8 small sp at 0x7F", s_sp, 8'h7F);
    chk("R8 small top byte", s_st_rdata, 8'd120);
    s_push = 1; s_st_wdata = 8'hEE; tick(); s_push = 0; #1;
    chk("R11 small sp past range", s_sp, 8'h80);
    chk("R11 small stack read 0", s_st_rdata, 8'h00);

    finish_run();
  end
endmodule